// File: doc/BRIEF.md
# Two-Client Pipelined SRAM Bank Controller

This block runs one external bank made of two pipelined synchronous SRAM chips. The chips sit back to back in a single linear space of 36-bit words, and one decoded address bit chooses the chip select. Two internal clients share the bank. The first is a bulk graphics client. The second is an audio client that makes short, periodic bursts. Each client posts a start address, a direction and a beat count. When the controller accepts the request, it places one address per clock on the bus. Address and chip select change together on every beat, including where a burst runs from one chip into the other.

Read data comes back one cycle after its address. The controller attaches a valid flag and an owner tag to each returned word, aligned to that one-cycle latency. A write beat takes its data from the owning client in the same cycle as the address. The client is told which cycles are its write beats by a per-client strobe.

Arbitration happens only at burst boundaries. A new burst can start in the cycle right after the last beat of the previous one, so no idle or turnaround cycle is inserted between bursts. Audio wins any boundary at which both clients are waiting. A burst that has been granted always runs to completion.

Top module: `sram_bank_ctl`

## Requirements
- R1: After reset both chip selects are high (`sram_cs_n` = 2'b11), `sram_we_n` is high, `sram_doe` is low, `rd_valid` is low and no grant is given while no client requests.
- R2: For a beat at 20-bit word address A, bit 19 of A picks the chip: A[19]=0 drives `sram_cs_n`=2'b10 (chip 0 selected), A[19]=1 drives 2'b01 (chip 1 selected), and `sram_addr` carries A[18:0].
- R3: The word read at an address presented in cycle N appears on `rd_data` with `rd_valid` high in cycle N+1, passed straight from `sram_din`.
- R4: A burst with length field L occupies exactly L+1 consecutive cycles on the bus, with addresses A, A+1, … A+L.
- R5: A burst that runs from address 0x7FFFF to 0x80000 switches the chip select in the same cycle as the address, with no gap.
- R6: When both clients request at a free boundary, the audio client is granted first.
- R7: A granted burst is never cut short: an audio request arriving during a graphics burst of L+1 beats is granted exactly L+1 cycles after the graphics grant.
- R8: Every returned read word carries `rd_tag` naming its owner (0 = graphics, 1 = audio).
- R9: On a write beat `sram_we_n` is low, `sram_doe` is high, `sram_dout` equals the owning client's write data in that cycle, and only the owner's write strobe is high.
- R10: While a further burst is pending, the bus is never idle between bursts, including when one burst reads and the next writes.
- R11: A burst running past address 0xFFFFF continues at address 0 (chip 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gfx_req | input | 1 | Graphics client requests a burst |
| gfx_we | input | 1 | Graphics burst is a write |
| gfx_addr | input | 20 | Graphics start word address |
| gfx_len | input | 6 | Graphics beats minus one |
| gfx_wdata | input | 36 | Graphics write data for the current beat |
| gfx_gnt | output | 1 | Graphics request accepted at this edge |
| gfx_wbeat | output | 1 | Graphics write beat on the bus this cycle |
| aud_req | input | 1 | Audio client requests a burst |
| aud_we | input | 1 | Audio burst is a write |
| aud_addr | input | 20 | Audio start word address |
| aud_len | input | 6 | Audio beats minus one |
| aud_wdata | input | 36 | Audio write data for the current beat |
| aud_gnt | output | 1 | Audio request accepted at this edge |
| aud_wbeat | output | 1 | Audio write beat on the bus this cycle |
| rd_valid | output | 1 | Read word valid |
| rd_tag | output | 1 | Owner of the read word |
| rd_data | output | 36 | Read word |
| sram_cs_n | output | 2 | Active-low chip selects, one per chip |
| sram_we_n | output | 1 | Active-low write enable |
| sram_addr | output | 19 | Word address within the chip |
| sram_doe | output | 1 | Drive enable for write data |
| sram_dout | output | 36 | Write data to the bank |
| sram_din | input | 36 | Read data from the bank |

## Verification
The hardest case to reach from the ports is a boundary at which a burst ends while the other client has already been waiting. That case tests priority, the absence of a gap, and a change of direction all at once. The stimulus gets there by forking both client drivers in the same cycle. It also starts an audio request a few cycles into a long graphics burst, and it puts a write right behind a read. A monitor flags any idle bus cycle while expected beats are still queued. The chip-boundary and end-of-bank crossings come from start addresses placed two beats and one beat before the edge.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
    typedef enum logic {
        CL_GFX = 1'b0,
        CL_AUD = 1'b1
    } client_e;
endpackage

// File: rtl/sram_arb.sv
module sram_arb
    import sram_bank_pkg::*;
(
    input  logic    slot_free,
    input  logic    gfx_req,
    input  logic    aud_req,
    output logic    gfx_gnt,
    output logic    aud_gnt,
    output logic    load,
    output client_e pick
);
    always_comb begin
        aud_gnt = slot_free && aud_req;
        gfx_gnt = slot_free && gfx_req && !aud_req;
        load    = aud_gnt || gfx_gnt;
        pick    = aud_req ? CL_AUD : CL_GFX;
    end
endmodule

// File: rtl/sram_burst.sv
module sram_burst
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  client_e           pick,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    output logic              active,
    output client_e           owner,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic              slot_free
);
    typedef struct packed {
        logic              active;
        client_e           owner;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } bst_t;

    bst_t st_d, st_q;

    assign slot_free = !st_q.active || (st_q.left == '0);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.active = 1'b1;
            st_d.owner  = pick;
            st_d.we     = ld_we;
            st_d.addr   = ld_addr;
            st_d.left   = ld_len;
        end else if (slot_free) begin
            st_d.active = 1'b0;
        end else begin
            st_d.addr = st_q.addr + 1'b1;
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, owner: CL_GFX, we: 1'b0, addr: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign owner  = st_q.owner;
    assign we     = st_q.we;
    assign addr   = st_q.addr;

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.left != '0) |=> (st_q.active && $stable(st_q.owner) && $stable(st_q.we)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.left != '0) |=> (st_q.addr == $past(st_q.addr) + 1'b1));
endmodule

// File: rtl/sram_cs_dec.sv
module sram_cs_dec #(
    parameter int ADDR_W    = 20,
    parameter int CHIP_BITS = 1
) (
    input  logic                        active,
    input  logic [ADDR_W-1:0]           addr,
    output logic [(2**CHIP_BITS)-1:0]   cs_n,
    output logic [ADDR_W-CHIP_BITS-1:0] row
);
    localparam int NCHIP = 2 ** CHIP_BITS;
    localparam int ROW_W = ADDR_W - CHIP_BITS;

    logic [CHIP_BITS-1:0] chip;
    assign chip = addr[ADDR_W-1 -: CHIP_BITS];
    assign row  = addr[ROW_W-1:0];

    for (genvar g = 0; g < NCHIP; g++) begin : g_cs
        assign cs_n[g] = !(active && (chip == CHIP_BITS'(g)));
    end
endmodule

// File: rtl/sram_rdpipe.sv
module sram_rdpipe
    import sram_bank_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_rd,
    input  client_e           issue_tag,
    input  logic [DATA_W-1:0] din,
    output logic              rd_valid,
    output client_e           rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic    valid;
        client_e tag;
    } rp_t;

    rp_t rp_d, rp_q;

    always_comb begin
        rp_d.valid = issue_rd;
        rp_d.tag   = issue_rd ? issue_tag : rp_q.tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '{valid: 1'b0, tag: CL_GFX};
        end else begin
            rp_q <= rp_d;
        end
    end

    assign rd_valid = rp_q.valid;
    assign rd_tag   = rp_q.tag;
    assign rd_data  = din;

    // R3, R8
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rd |=> (rd_valid && rd_tag == $past(issue_tag)));
endmodule

// File: rtl/sram_bank_ctl.sv
module sram_bank_ctl
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 36,
    parameter int LEN_W     = 6,
    parameter int CHIP_BITS = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            gfx_req,
    input  logic                            gfx_we,
    input  logic [ADDR_W-1:0]               gfx_addr,
    input  logic [LEN_W-1:0]                gfx_len,
    input  logic [DATA_W-1:0]               gfx_wdata,
    output logic                            gfx_gnt,
    output logic                            gfx_wbeat,
    input  logic                            aud_req,
    input  logic                            aud_we,
    input  logic [ADDR_W-1:0]               aud_addr,
    input  logic [LEN_W-1:0]                aud_len,
    input  logic [DATA_W-1:0]               aud_wdata,
    output logic                            aud_gnt,
    output logic                            aud_wbeat,
    output logic                            rd_valid,
    output logic                            rd_tag,
    output logic [DATA_W-1:0]               rd_data,
    output logic [(2**CHIP_BITS)-1:0]       sram_cs_n,
    output logic                            sram_we_n,
    output logic [ADDR_W-CHIP_BITS-1:0]     sram_addr,
    output logic                            sram_doe,
    output logic [DATA_W-1:0]               sram_dout,
    input  logic [DATA_W-1:0]               sram_din
);
    logic              slot_free, load, ld_we;
    client_e           pick, b_owner, r_tag;
    logic [ADDR_W-1:0] ld_addr, b_addr;
    logic [LEN_W-1:0]  ld_len;
    logic              b_active, b_we;

    sram_arb u_arb (
        .slot_free (slot_free),
        .gfx_req   (gfx_req),
        .aud_req   (aud_req),
        .gfx_gnt   (gfx_gnt),
        .aud_gnt   (aud_gnt),
        .load      (load),
        .pick      (pick)
    );

    always_comb begin
        ld_we   = (pick == CL_AUD) ? aud_we   : gfx_we;
        ld_addr = (pick == CL_AUD) ? aud_addr : gfx_addr;
        ld_len  = (pick == CL_AUD) ? aud_len  : gfx_len;
    end

    sram_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .pick      (pick),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_len    (ld_len),
        .active    (b_active),
        .owner     (b_owner),
        .we        (b_we),
        .addr      (b_addr),
        .slot_free (slot_free)
    );

    sram_cs_dec #(.ADDR_W(ADDR_W), .CHIP_BITS(CHIP_BITS)) u_dec (
        .active (b_active),
        .addr   (b_addr),
        .cs_n   (sram_cs_n),
        .row    (sram_addr)
    );

    sram_rdpipe #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_rd  (b_active && !b_we),
        .issue_tag (b_owner),
        .din       (sram_din),
        .rd_valid  (rd_valid),
        .rd_tag    (r_tag),
        .rd_data   (rd_data)
    );
    assign rd_tag = r_tag;

    always_comb begin
        sram_doe  = b_active && b_we;
        sram_we_n = !sram_doe;
        gfx_wbeat = sram_doe && (b_owner == CL_GFX);
        aud_wbeat = sram_doe && (b_owner == CL_AUD);
        sram_dout = !sram_doe ? '0 : ((b_owner == CL_AUD) ? aud_wdata : gfx_wdata);
    end

    // R6
    aud_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aud_gnt |=> (b_active && b_owner == CL_AUD));

    // R9
    wr_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gfx_wbeat || aud_wbeat) |-> (!sram_we_n && sram_doe && !(&sram_cs_n)));
endmodule

// File: tb/sim_sram_bank_ctl.sv
module sim_sram_bank_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gfx_req = 0, gfx_we = 0, aud_req = 0, aud_we = 0;
    logic [19:0] gfx_addr = '0, aud_addr = '0;
    logic [5:0]  gfx_len = '0, aud_len = '0;
    logic [35:0] gfx_wdata, aud_wdata;
    logic        gfx_gnt, aud_gnt, gfx_wbeat, aud_wbeat;
    logic        rd_valid, rd_tag;
    logic [35:0] rd_data, sram_dout;
    logic [35:0] sram_din = '0;
    logic [1:0]  sram_cs_n;
    logic        sram_we_n, sram_doe;
    logic [18:0] sram_addr;

    always #2 clk = ~clk;

    sram_bank_ctl u0 (.*);

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    int wcnt [2] = '{0, 0};
    int wcnt_act [2] = '{0, 0};
    logic [35:0] mem [int];

    typedef struct { logic [1:0] csn; logic [18:0] row; bit wr; logic [35:0] wd; bit own; } bus_t;
    typedef struct { bit own; logic [35:0] d; } rd_t;
    bus_t busq [$];
    rd_t  rdq [$];

    function automatic logic [35:0] wval(bit c, int n);
        return {3'b101, c, 32'(n) * 32'h9E3779B1};
    endfunction

    function automatic logic [35:0] peek(int a);
        if (mem.exists(a)) return mem[a];
        return {a[19:0], 16'hA5C3};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // write data sources: one word per write beat, in order
    assign gfx_wdata = wval(1'b0, wcnt_act[0]);
    assign aud_wdata = wval(1'b1, wcnt_act[1]);
    always @(posedge clk) begin
        if (gfx_wbeat) wcnt_act[0] <= wcnt_act[0] + 1;
        if (aud_wbeat) wcnt_act[1] <= wcnt_act[1] + 1;
    end

    // SRAM bank model: two chips, one-cycle read pipeline
    always @(posedge clk) begin
        if (sram_cs_n != 2'b11) begin
            int a;
            a = {sram_cs_n == 2'b01, sram_addr};
            if (!sram_we_n) mem[a] = sram_dout;
            else sram_din <= peek(a);
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                if (rdq.size() == 0) chk("R3 unexpected read word", 1, 0);
                else begin
                    rd_t e;
                    e = rdq.pop_front();
                    chk("R8 read tag", rd_tag, e.own);
                    chk("R3 read data", rd_data, e.d);
                end
            end else if (rdq.size() != 0) begin
                chk("R3 read word late", 0, 1);
            end
            if (sram_cs_n != 2'b11) begin
                if (busq.size() == 0) chk("R4 extra bus beat", 1, 0);
                else begin
                    bus_t b;
                    b = busq.pop_front();
                    chk("R2 chip select", sram_cs_n, b.csn);
                    chk("R2 row address", sram_addr, b.row);
                    chk("R9 write enable", sram_we_n, !b.wr);
                    chk("R9 write strobes", {gfx_wbeat, aud_wbeat}, {b.wr && !b.own, b.wr && b.own});
                    if (b.wr) begin
                        chk("R9 write data", sram_dout, b.wd);
                        chk("R9 drive enable", sram_doe, 1);
                    end else begin
                        rd_t r;
                        r.own = b.own;
                        r.d = peek({b.csn == 2'b01, b.row});
                        rdq.push_back(r);
                    end
                end
            end else if (busq.size() != 0) begin
                chk("R10 idle bus with burst pending", 1, 0);
            end
        end
    end

    task automatic issue(bit c, bit w, logic [19:0] a, int len, output int stamp);
        @(negedge clk);
        if (c) begin aud_req = 1; aud_we = w; aud_addr = a; aud_len = 6'(len); end
        else   begin gfx_req = 1; gfx_we = w; gfx_addr = a; gfx_len = 6'(len); end
        #1;
        while (!(c ? aud_gnt : gfx_gnt)) begin
            @(negedge clk);
            #1;
        end
        stamp = cyc;
        for (int k = 0; k <= len; k++) begin
            bus_t b;
            logic [19:0] ak;
            ak = a + 20'(k);
            b.csn = ak[19] ? 2'b01 : 2'b10;
            b.row = ak[18:0];
            b.wr = w;
            b.own = c;
            b.wd = w ? wval(c, wcnt[c]) : '0;
            if (w) wcnt[c]++;
            busq.push_back(b);
        end
        @(negedge clk);
        if (c) aud_req = 0; else gfx_req = 0;
    endtask

    task automatic drain();
        do @(negedge clk); while (busq.size() != 0 || rdq.size() != 0);
        @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        int sa, sg, s0, s1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chip selects", sram_cs_n, 2'b11);
        chk("R1 write enable", sram_we_n, 1);
        chk("R1 drive enable", sram_doe, 0);
        chk("R1 read valid", rd_valid, 0);
        chk("R1 grants", {gfx_gnt, aud_gnt}, 2'b00);

        // R2 R3 R4: chip 0 read, then chip 1 read
        issue(0, 0, 20'h00010, 3, s0);
        drain();
        issue(0, 0, 20'h80020, 2, s0);
        drain();
        // R5: burst crossing chip boundary
        issue(0, 0, 20'h7FFFE, 3, s0);
        drain();
        // R11: burst wrapping past end of bank
        issue(1, 0, 20'hFFFFF, 1, s0);
        drain();
        // R9: writes from both clients then read back
        issue(1, 1, 20'h00100, 3, s0);
        drain();
        issue(0, 1, 20'h7FFFF, 2, s0);
        drain();
        issue(1, 0, 20'h00100, 3, s0);
        drain();
        issue(0, 0, 20'h7FFFF, 2, s0);
        drain();
        // R6 + R10: simultaneous requests
        fork
            issue(0, 0, 20'h00200, 4, sg);
            issue(1, 0, 20'h90000, 2, sa);
        join
        chk("R6 audio granted first", sa < sg, 1);
        chk("R10 next grant right after last beat", sg, sa + 3);
        drain();
        // R7: audio arrives mid graphics burst
        issue(0, 0, 20'h01000, 7, sg);
        repeat (2) @(negedge clk);
        issue(1, 0, 20'h02000, 1, sa);
        chk("R7 graphics burst not cut short", sa, sg + 8);
        drain();
        // R10: read followed by write with no gap
        fork
            issue(0, 0, 20'h03000, 2, s0);
            begin
                @(negedge clk);
                @(negedge clk);
                issue(1, 1, 20'h04000, 1, s1);
            end
        join
        chk("R10 read to write switch", s1, s0 + 3);
        drain();
        // R4 R10: single-beat bursts back to back
        fork
            issue(0, 1, 20'h05000, 0, s0);
            issue(1, 0, 20'h00100, 0, s1);
        join
        chk("R10 single-beat back to back", s0, s1 + 1);
        drain();
        issue(0, 0, 20'h05000, 0, s0);
        drain();
        chk("R4 queues empty", busq.size() + rdq.size(), 0);
        done = 1;
        report();
    end
endmodule